// File: doc/BRIEF.md
# Battery-Domain Seconds Counter with Bus Register Access

This block keeps wall-clock time in a free-running 47-bit counter that advances on every rising edge of a slow 32768 Hz clock. The counter is read as a fixed-point seconds value: the low 15 bits are the fraction of a second and the upper 32 bits are whole seconds. Software sees the block through a 32-bit register interface on a separate, unrelated bus clock. A control word holds the run request and a small signed calibration trim. The counter itself is visible as two words, one for bits 46:32 and one for bits 31:0.

All control state crosses into the slow domain through two-flop synchronisers. The "running" bit software reads back is the enable state that has actually arrived in the slow domain, returned through a second synchroniser. Software sets the time by clearing the run request, polling until the readback shows stopped, writing both counter words, and then setting the run request again. Counting begins only after a two-cycle start delay in the slow domain. Each counter word is read separately and nothing is latched between the two reads, so a pair of reads taken while the counter is running may not match. Software resolves this by reading the pair again until two passes agree.

Top module: `rtc_secure_counter`

## Requirements
- R1: After reset, the run request, the calibration enable, the calibration trim, the staged load value and the counter are all zero, so every register reads 0.
- R2: While running and with calibration off, the counter adds 1 on each slow-clock rising edge and wraps from 2^47-1 to 0.
- R3: Byte offset 0x38 is the control word: bit 0 is the run request on write and the reached run state on read, bit 8 enables calibration, and bits 14:10 hold the trim. Offset 0x50 carries counter bits 46:32 in bits 14:0. Offset 0x54 carries counter bits 31:0. Unused bits and all other offsets read 0. Read data is valid on the bus clock edge after the read strobe.
- R4: After bit 0 is written to 1, the first count happens on the fifth slow-clock rising edge, so T edges yield T-4 counts for T>=4. After bit 0 is written to 0, exactly two more counts occur, and then the counter holds.
- R5: The bit 0 readback stays 0 after a write of 1 until two slow-clock edges and then two bus-clock edges have passed. It returns to 0 by the same path after a write of 0.
- R6: Writes to offsets 0x50 and 0x54 are ignored while the bit 0 readback is 1. They change neither the running value nor the value held after a later stop.
- R7: Counter words written while stopped are loaded into the counter by the third slow-clock edge after the write. A stopped counter with no pending write keeps its value.
- R8: When calibration is enabled, every CAL_PERIOD-th count adds 1 plus the trim, read as a 5-bit two's-complement value (-16..15), instead of 1. The period count restarts whenever the block is stopped. When calibration is disabled, the trim has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| slow_clk | input | 1 | 32768 Hz counting clock, asynchronous to bus_clk |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_rd | input | 1 | Read strobe, one bus cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |

## Verification
The counter can take a calibration boundary step on the same slow edge as one of the two trailing counts that follow a stop request. In that case the trimmed step has to be applied while the run request is already being withdrawn. The bench provokes this by sweeping the full range of trim values with a run length that puts the third period boundary on the second trailing count. It judges each result against the closed form L + n + floor(n/CAL_PERIOD)·trim, taken modulo 2^47. Ignored counter writes are placed inside a run, and the counter value after the stop shows whether any of them reached the counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h54;

    // control word fields
    localparam int unsigned CTRL_RUN_BIT = 0;
    localparam int unsigned CTRL_CAL_BIT = 8;
    localparam int unsigned CTRL_TRIM_LSB = 10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_HI,
        SEL_LO
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == OFS_CTRL)        return SEL_CTRL;
        else if (a == OFS_CNT_HI) return SEL_HI;
        else if (a == OFS_CNT_LO) return SEL_LO;
        else                      return SEL_NONE;
    endfunction

endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] s0;
        logic [W-1:0] s1;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s0 = d;
        st_d.s1 = st_q.s0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s1;

endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core #(
    parameter int unsigned CNT_W      = 47,
    parameter int unsigned TRIM_W     = 5,
    parameter int unsigned CAL_PERIOD = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_s,
    input  logic              cal_on_s,
    input  logic [TRIM_W-1:0] trim_s,
    input  logic              pend_s,
    input  logic [CNT_W-1:0]  stage_s,
    output logic [CNT_W-1:0]  cnt
);

    localparam int unsigned PER_W = (CAL_PERIOD > 1) ? $clog2(CAL_PERIOD) : 1;
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(CAL_PERIOD - 1);
    localparam int unsigned EXT_W = CNT_W - TRIM_W;

    typedef struct packed {
        logic [1:0]       dly;
        logic [PER_W-1:0] per;
        logic [CNT_W-1:0] cnt;
    } core_t;

    core_t c_d, c_q;
    logic             live;
    logic             at_bound;
    logic [CNT_W-1:0] step;

    always_comb begin
        c_d      = c_q;
        live     = run_s && c_q.dly[1];
        at_bound = (c_q.per == PER_LAST);
        step     = CNT_W'(1);
        if (cal_on_s && at_bound)
            step = CNT_W'(1) + {{EXT_W{trim_s[TRIM_W-1]}}, trim_s};

        // two-cycle start delay after the synchronised run bit rises
        c_d.dly = run_s ? {c_q.dly[0], 1'b1} : 2'b00;

        if (!run_s) begin
            c_d.per = '0;
            if (pend_s)
                c_d.cnt = stage_s;
        end else if (live) begin
            c_d.cnt = c_q.cnt + step;
            c_d.per = at_bound ? '0 : c_q.per + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt = c_q.cnt;

    // R4: no count on the two edges after the run bit arrives
    p_start_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_s) |=> $stable(c_q.cnt) ##1 $stable(c_q.cnt));

    // R7: stopped with nothing pending holds the counter
    p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_s && !pend_s) |=> $stable(c_q.cnt));

    // R2: plain step of one when calibration is off
    p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !cal_on_s) |=> (c_q.cnt == $past(c_q.cnt) + CNT_W'(1)));

    // R8: period counter never passes its last value
    p_period_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.per == PER_LAST) |=> (c_q.per == PER_LAST && !$past(live)) || c_q.per == '0);

endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W  = 47,
    parameter int unsigned TRIM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              run_seen,
    input  logic [CNT_W-1:0]  cnt_seen,
    output logic              run_req,
    output logic              cal_on,
    output logic [TRIM_W-1:0] trim,
    output logic              pend,
    output logic [CNT_W-1:0]  stage
);

    localparam int unsigned HI_W = CNT_W - BUS_W;

    typedef struct packed {
        logic              run_req;
        logic              cal_on;
        logic [TRIM_W-1:0] trim;
        logic              pend;
        logic [HI_W-1:0]   st_hi;
        logic [BUS_W-1:0]  st_lo;
        logic [BUS_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;
    reg_sel_e sel;
    logic [BUS_W-1:0] ctrl_word;
    logic [BUS_W-1:0] hi_word;

    generate
        if (HI_W < BUS_W) begin : g_hi_pad
            assign hi_word = {{(BUS_W-HI_W){1'b0}}, cnt_seen[CNT_W-1:BUS_W]};
        end else begin : g_hi_full
            assign hi_word = cnt_seen[BUS_W+BUS_W-1:BUS_W];
        end
    endgenerate

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_RUN_BIT] = run_seen;
        ctrl_word[CTRL_CAL_BIT] = r_q.cal_on;
        ctrl_word[CTRL_TRIM_LSB +: TRIM_W] = r_q.trim;
    end

    always_comb begin
        r_d = r_q;
        sel = decode_addr(addr);
        if (wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    r_d.run_req = wdata[CTRL_RUN_BIT];
                    r_d.cal_on  = wdata[CTRL_CAL_BIT];
                    r_d.trim    = wdata[CTRL_TRIM_LSB +: TRIM_W];
                    if (wdata[CTRL_RUN_BIT])
                        r_d.pend = 1'b0;
                end
                SEL_HI: if (!run_seen) begin
                    r_d.st_hi = wdata[HI_W-1:0];
                    r_d.pend  = 1'b1;
                end
                SEL_LO: if (!run_seen) begin
                    r_d.st_lo = wdata;
                    r_d.pend  = 1'b1;
                end
                default: ;
            endcase
        end
        if (rd) begin
            unique case (sel)
                SEL_CTRL: r_d.rdata = ctrl_word;
                SEL_HI:   r_d.rdata = hi_word;
                SEL_LO:   r_d.rdata = cnt_seen[BUS_W-1:0];
                default:  r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata   = r_q.rdata;
    assign run_req = r_q.run_req;
    assign cal_on  = r_q.cal_on;
    assign trim    = r_q.trim;
    assign pend    = r_q.pend;
    assign stage   = {r_q.st_hi, r_q.st_lo};

    // R6: counter writes while running leave the staged value alone
    p_ignore_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_CNT_HI && run_seen) |=> $stable(r_q.st_hi));
    p_ignore_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFS_CNT_LO && run_seen) |=> $stable(r_q.st_lo));

    // R3: unused control bits read as zero
    p_ctrl_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == OFS_CTRL) |=>
            (rdata[BUS_W-1:15] == '0 && rdata[9] == 1'b0 && rdata[7:1] == '0));

    // R3: unmapped offsets read as zero
    p_unmapped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr != OFS_CTRL && addr != OFS_CNT_HI && addr != OFS_CNT_LO) |=> (rdata == '0));

endmodule

// File: rtl/rtc_secure_counter.sv
module rtc_secure_counter
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W      = 47,
    parameter int unsigned TRIM_W     = 5,
    parameter int unsigned CAL_PERIOD = 32768
) (
    input  logic              bus_clk,
    input  logic              slow_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);

    localparam int unsigned DN_W = 3 + TRIM_W + CNT_W;
    localparam int unsigned UP_W = 1 + CNT_W;

    logic              run_req, cal_on, pend;
    logic [TRIM_W-1:0] trim;
    logic [CNT_W-1:0]  stage;

    logic              run_s, cal_on_s, pend_s;
    logic [TRIM_W-1:0] trim_s;
    logic [CNT_W-1:0]  stage_s;
    logic [CNT_W-1:0]  cnt_slow;

    logic              run_seen;
    logic [CNT_W-1:0]  cnt_seen;

    rtc_bus_regs #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_regs (
        .clk      (bus_clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .run_seen (run_seen),
        .cnt_seen (cnt_seen),
        .run_req  (run_req),
        .cal_on   (cal_on),
        .trim     (trim),
        .pend     (pend),
        .stage    (stage)
    );

    rtc_sync2 #(.W(DN_W)) u_to_slow (
        .clk   (slow_clk),
        .rst_n (rst_n),
        .d     ({run_req, cal_on, trim, pend, stage}),
        .q     ({run_s, cal_on_s, trim_s, pend_s, stage_s})
    );

    rtc_slow_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .CAL_PERIOD(CAL_PERIOD)) u_core (
        .clk      (slow_clk),
        .rst_n    (rst_n),
        .run_s    (run_s),
        .cal_on_s (cal_on_s),
        .trim_s   (trim_s),
        .pend_s   (pend_s),
        .stage_s  (stage_s),
        .cnt      (cnt_slow)
    );

    rtc_sync2 #(.W(UP_W)) u_to_bus (
        .clk   (bus_clk),
        .rst_n (rst_n),
        .d     ({run_s, cnt_slow}),
        .q     ({run_seen, cnt_seen})
    );

endmodule

// File: tb/test_rtc_secure_counter.sv
module test_rtc_secure_counter;

    localparam int P = 4;
    localparam longint unsigned MASK = (64'd1 << 47) - 1;

    logic        bus_clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails = 0;

    rtc_secure_counter #(.CAL_PERIOD(P)) i_rtc_secure_counter (
        .bus_clk   (bus_clk),
        .slow_clk  (slow_clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #10 bus_clk = ~bus_clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge bus_clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge bus_clk); slow_clk = 1'b1;
            repeat (2) @(negedge bus_clk);
            slow_clk = 1'b0;
            repeat (2) @(negedge bus_clk);
        end
    endtask

    task automatic rd_cnt(output logic [63:0] v);
        logic [31:0] h, l;
        repeat (3) @(negedge bus_clk);
        rd_reg(8'h50, h);
        rd_reg(8'h54, l);
        v = {h, l};
    endtask

    function automatic logic [63:0] model(input longint unsigned l, input int n,
                                          input bit cen, input int trim);
        longint v;
        v = longint'(l) + n;
        if (cen) v = v + longint'(n / P) * trim;
        return 64'(v) & MASK;
    endfunction

    function automatic logic [31:0] ctrl(input bit run, input bit cen, input int trim);
        return {17'd0, 5'(trim), 1'b0, cen, 7'd0, run};
    endfunction

    // one load / run / stop cycle; T >= 4 slow edges while running
    task automatic episode(input string tag, input longint unsigned l, input int t,
                           input bit cen, input int trim, input bit poke);
        logic [63:0] v;
        logic [31:0] s;
        int n;
        n = t - 4;
        wr_reg(8'h38, ctrl(1'b0, cen, trim));
        wr_reg(8'h50, 32'(l >> 32));
        wr_reg(8'h54, 32'(l));
        tick(3);
        rd_cnt(v);
        chk({"R7 load ", tag}, v, l & MASK);
        wr_reg(8'h38, ctrl(1'b1, cen, trim));
        tick(t);
        rd_cnt(v);
        chk({"R4 R2 R8 running ", tag}, v, model(l, n, cen, trim));
        if (poke) begin
            wr_reg(8'h50, 32'h0000_1234);
            wr_reg(8'h54, 32'hDEAD_BEEF);
            rd_cnt(v);
            chk({"R6 ignored while running ", tag}, v, model(l, n, cen, trim));
        end
        wr_reg(8'h38, ctrl(1'b0, cen, trim));
        tick(3);
        rd_cnt(v);
        chk({"R4 R8 stop adds two ", tag}, v, model(l, n + 2, cen, trim));
        rd_reg(8'h38, s);
        chk({"R5 stopped readback ", tag}, 64'(s[0]), 64'd0);
        if (poke) begin
            tick(3);
            rd_cnt(v);
            chk({"R6 R7 hold after stop ", tag}, v, model(l, n + 2, cen, trim));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge bus_clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [63:0] v;
        repeat (3) @(negedge bus_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge bus_clk);

        // R1 reset state
        rd_reg(8'h38, d); chk("R1 ctrl after reset", 64'(d), 64'd0);
        rd_reg(8'h50, d); chk("R1 hi after reset", 64'(d), 64'd0);
        rd_reg(8'h54, d); chk("R1 lo after reset", 64'(d), 64'd0);

        // R3 field layout and reserved bits
        wr_reg(8'h38, 32'hFFFF_FFFE);
        rd_reg(8'h38, d); chk("R3 ctrl fields", 64'(d), 64'h0000_7D00);
        rd_reg(8'h3C, d); chk("R3 unmapped offset", 64'(d), 64'd0);
        wr_reg(8'h38, 32'h0);

        // R3 R2 R5 wrap with readback lag; hi written with all ones
        wr_reg(8'h50, 32'hFFFF_FFFF);
        wr_reg(8'h54, 32'hFFFF_FFFD);
        tick(3);
        rd_reg(8'h50, d); chk("R3 hi truncated to 15 bits", 64'(d), 64'h7FFF);
        rd_reg(8'h54, d); chk("R7 lo loaded", 64'(d), 64'hFFFF_FFFD);
        wr_reg(8'h38, 32'h1);
        repeat (6) @(negedge bus_clk);
        rd_reg(8'h38, d); chk("R5 readback before slow edges", 64'(d[0]), 64'd0);
        tick(1);
        rd_reg(8'h38, d); chk("R5 readback after one edge", 64'(d[0]), 64'd0);
        tick(1);
        rd_reg(8'h38, d); chk("R5 readback after two edges", 64'(d[0]), 64'd1);
        tick(7);
        rd_cnt(v);
        chk("R2 wrap to two", v, 64'd2);
        wr_reg(8'h38, 32'h0);
        tick(3);
        rd_cnt(v);
        chk("R2 R4 wrap after stop", v, 64'd4);

        // R4 R2 run-length sweep, trim set but calibration off (R8)
        for (int t = 4; t <= 12; t++)
            episode($sformatf("len t=%0d", t), 64'd1000 + 64'(t), t, 1'b0, 7, t == 10);

        // R8 full trim sweep; third boundary lands on the second trailing count
        for (int tr = -16; tr <= 15; tr++)
            episode($sformatf("trim=%0d", tr), 64'h1_0000_0000, 14, 1'b1, tr, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule